// File: doc/BRIEF.md
# Two-Level Aperture Address Translator

This block maps bus addresses that land inside a programmable aperture window onto physical page addresses. The mapping lives in system memory as a two-level structure. A directory holds pointers to page tables, and each page table holds 1024 four-byte page entries. The block reads entries through a simple memory read port. It keeps its most recent results in a small fully associative translation cache. Addresses outside the window are returned unchanged.

Software programs four values through a word-wide register interface: the directory base, the aperture base, the aperture size mask and a control byte. Bit 0 of the control byte enables the cache. After software changes the tables, it invalidates the cache through two self-clearing flush registers. The first is the posted flush and the second is the directory flush. Software writes 1 to each in turn and polls until it reads back 0. Translation requests use a valid/ready handshake. Each request returns exactly one response, carrying either a translated address or an error.

Top module: `aperture_xlate`

## Requirements
- R1: After reset, the register reads are as follows. Offset 0x00 reads 0x00010000, meaning control byte 0x01 in bits 23:16 with the cache enabled. Offsets 0x0C and 0x14 read 0. The size mask at 0x1C reads 0xFE000000. `xl_ready` is 1 and `rsp_valid` is 0.
- R2: An address is outside the aperture when ((addr ^ base) & mask) has bits 31:25 nonzero. Such an address is answered on the cycle after acceptance with `rsp_addr` equal to the address and `rsp_err` 0. No memory read is issued for it.
- R3: A cache miss inside the aperture makes two memory reads, in this order:
  - First, the directory entry at base_dir + 4 × (addr[31:22] − aperture_base[31:22]).
  - Second, the page entry at (dir_entry & 0xFFFFF000) + 4 × addr[21:12].
  
  The response is {page_entry[31:12], addr[11:0]} with `rsp_err` 0.
- R4: Bit 0 of each entry is its valid bit. A clear bit ends the walk with `rsp_err` 1 and `rsp_addr` 0. An invalid directory entry causes exactly one memory read; an invalid page entry causes two.
- R5: While control bit 0 is 1, a request to a page translated earlier is answered on the next cycle from the cache, with no memory read.
- R6: While control bit 0 is 0, every request inside the aperture performs the full walk.
- R7: Writing a value with bit 0 set to the posted flush (0x14) or the directory flush (0x0C) makes that register read 1 for at least one cycle and then 0. After either flush, pages cached before it must be walked again.
- R8: `xl_ready` is 0 while a walk is in progress or while either flush is busy. Only one walk is outstanding at any time.
- R9: The size mask register at 0x1C accepts only the values 0x80000000, 0xC0000000, and so on through 0xFE000000, where each step halves the aperture. Any other write leaves it unchanged. Bits 24:0 always read 0. The aperture check uses the current mask.
- R10: The cache holds 8 entries, filled in round-robin order. After nine distinct pages are walked following a flush, the first page misses and the second still hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; data appears the next cycle |
| reg_addr | input | 8 | Register byte offset (word aligned) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| xl_valid | input | 1 | Translation request valid |
| xl_ready | output | 1 | Translation request accepted when high |
| xl_addr | input | 32 | Bus address to translate |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_addr | output | 32 | Translated or passed-through address |
| rsp_err | output | 1 | Walk reached an invalid entry |
| mem_req | output | 1 | One-cycle memory read request |
| mem_addr | output | 32 | Memory read address |
| mem_rvalid | input | 1 | Memory read data valid |
| mem_rdata | input | 32 | Memory read data |

## Verification
The hardest situation to reach from the ports is round-robin eviction. The replacement pointer keeps advancing across flushes, and its position cannot be read. To show that the oldest entry goes first, the stimulus flushes the cache and then walks nine distinct pages. It probes the second page before the first, because a miss on the first page would refill a slot and evict the second. Flush visibility is also hard to show, because the busy bit lasts only a few cycles. The stimulus reads the flush register back in the cycle right after the write, and checks that `xl_ready` is low at that moment.

// File: rtl/apx_pkg.sv
package apx_pkg;
  localparam int PG_SH  = 12;
  localparam int DIR_SH = 22;
  localparam int IDX_W  = 10;
  localparam int VPN_W  = 32 - PG_SH;
  localparam int MSK_W  = 7;

  localparam logic [7:0] OFF_CTRL  = 8'h00;
  localparam logic [7:0] OFF_TBASE = 8'h04;
  localparam logic [7:0] OFF_DFL   = 8'h0C;
  localparam logic [7:0] OFF_PFL   = 8'h14;
  localparam logic [7:0] OFF_ABASE = 8'h18;
  localparam logic [7:0] OFF_AMASK = 8'h1C;

  typedef enum logic [1:0] {S_IDLE, S_DIR, S_PT} walk_st_t;

  function automatic logic mask_ok(logic [MSK_W-1:0] m);
    logic [MSK_W-1:0] n;
    n = ~m;
    return m[MSK_W-1] && ((n & (n + 1'b1)) == '0);
  endfunction
endpackage

// File: rtl/apx_regs.sv
module apx_regs
  import apx_pkg::*;
#(
  parameter int FLUSH_CYCLES = 2,
  parameter logic [7:0] CTRL_RST = 8'h01
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                reg_wr,
  input  logic                reg_rd,
  input  logic [7:0]          reg_addr,
  input  logic [31:0]         reg_wdata,
  output logic [31:0]         reg_rdata,
  input  logic                walk_idle,
  output logic [7:0]          ctrl,
  output logic [VPN_W-1:0]    tbase,
  output logic [IDX_W-1:0]    abase,
  output logic [MSK_W-1:0]    amask,
  output logic                flush_busy,
  output logic                flush_done
);
  localparam int CW = $clog2(FLUSH_CYCLES + 1);

  logic [1:0] busy;
  logic [1:0] done;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl  <= CTRL_RST;
      tbase <= '0;
      abase <= '0;
      amask <= '1;
    end else if (reg_wr) begin
      case (reg_addr)
        OFF_CTRL:  ctrl  <= reg_wdata[23:16];
        OFF_TBASE: tbase <= reg_wdata[31:PG_SH];
        OFF_ABASE: abase <= reg_wdata[31:DIR_SH];
        OFF_AMASK: if (mask_ok(reg_wdata[31:32-MSK_W])) amask <= reg_wdata[31:32-MSK_W];
        default: ;
      endcase
    end
  end

  // index 0: posted flush, index 1: directory flush
  for (genvar g = 0; g < 2; g++) begin : g_fl
    localparam logic [7:0] MY_OFF = (g == 0) ? OFF_PFL : OFF_DFL;
    logic          bsy;
    logic [CW-1:0] cnt;
    always_ff @(posedge clk) begin
      if (rst) begin
        bsy <= 1'b0;
        cnt <= '0;
      end else if (!bsy) begin
        if (reg_wr && reg_addr == MY_OFF && reg_wdata[0]) begin
          bsy <= 1'b1;
          cnt <= CW'(FLUSH_CYCLES - 1);
        end
      end else if (walk_idle) begin
        if (cnt == '0) bsy <= 1'b0;
        else           cnt <= cnt - 1'b1;
      end
    end
    assign busy[g] = bsy;
    assign done[g] = bsy && walk_idle && (cnt == '0);
  end

  assign flush_busy = |busy;
  assign flush_done = |done;

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else if (reg_rd) begin
      case (reg_addr)
        OFF_CTRL:  reg_rdata <= {8'h00, ctrl, 16'h0000};
        OFF_TBASE: reg_rdata <= {tbase, {PG_SH{1'b0}}};
        OFF_DFL:   reg_rdata <= {31'd0, busy[1]};
        OFF_PFL:   reg_rdata <= {31'd0, busy[0]};
        OFF_ABASE: reg_rdata <= {abase, {DIR_SH{1'b0}}};
        OFF_AMASK: reg_rdata <= {amask, {(32-MSK_W){1'b0}}};
        default:   reg_rdata <= '0;
      endcase
    end
  end

  assert_mask_legal_R9: assert property (@(posedge clk) disable iff (rst)
    mask_ok(amask));

  assert_flush_seen_R7: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == OFF_PFL && reg_wdata[0] && !busy[0]) |=> busy[0]);
endmodule

// File: rtl/apx_tlb.sv
module apx_tlb
  import apx_pkg::*;
#(
  parameter int ENTRIES = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [VPN_W-1:0] lk_vpn,
  output logic             hit,
  output logic [VPN_W-1:0] hit_ppn,
  input  logic             fill,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [VPN_W-1:0] fill_ppn,
  input  logic             inval
);
  localparam int PW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [PW-1:0]      ptr;
  logic [ENTRIES-1:0] hv;
  logic [VPN_W-1:0]   ppn_a [ENTRIES];

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    logic             vld;
    logic [VPN_W-1:0] vpn;
    logic [VPN_W-1:0] ppn;
    always_ff @(posedge clk) begin
      if (rst || inval) vld <= 1'b0;
      else if (fill && ptr == PW'(i)) begin
        vld <= 1'b1;
        vpn <= fill_vpn;
        ppn <= fill_ppn;
      end
    end
    assign hv[i]    = vld && (vpn == lk_vpn);
    assign ppn_a[i] = ppn;
  end

  always_ff @(posedge clk) begin
    if (rst) ptr <= '0;
    else if (fill && !inval) ptr <= (ptr == PW'(ENTRIES - 1)) ? '0 : ptr + 1'b1;
  end

  always_comb begin
    hit_ppn = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (hv[i]) hit_ppn = hit_ppn | ppn_a[i];
  end
  assign hit = |hv;

  assert_single_hit_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hv));
endmodule

// File: rtl/apx_walker.sv
module apx_walker
  import apx_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             xl_valid,
  output logic             xl_ready,
  input  logic [31:0]      xl_addr,
  output logic             rsp_valid,
  output logic [31:0]      rsp_addr,
  output logic             rsp_err,
  output logic             mem_req,
  output logic [31:0]      mem_addr,
  input  logic             mem_rvalid,
  input  logic [31:0]      mem_rdata,
  input  logic             cache_en,
  input  logic [VPN_W-1:0] tbase,
  input  logic [IDX_W-1:0] abase,
  input  logic [MSK_W-1:0] amask,
  input  logic             flush_busy,
  input  logic             tlb_hit,
  input  logic [VPN_W-1:0] tlb_ppn,
  output logic             fill,
  output logic [VPN_W-1:0] fill_vpn,
  output logic [VPN_W-1:0] fill_ppn,
  output logic             walk_idle
);
  walk_st_t         st;
  logic [31:0]      cur;
  logic             in_ap;
  logic [IDX_W-1:0] dir_idx;
  logic             accept;

  always_comb begin
    in_ap    = ((xl_addr[31:32-MSK_W] ^ abase[IDX_W-1:IDX_W-MSK_W]) & amask) == '0;
    dir_idx  = xl_addr[31:DIR_SH] - abase;
    xl_ready = (st == S_IDLE) && !flush_busy;
    accept   = xl_valid && xl_ready;
  end

  assign walk_idle = (st == S_IDLE);
  assign fill_vpn  = cur[31:PG_SH];

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      cur       <= '0;
      mem_req   <= 1'b0;
      mem_addr  <= '0;
      rsp_valid <= 1'b0;
      rsp_addr  <= '0;
      rsp_err   <= 1'b0;
      fill      <= 1'b0;
      fill_ppn  <= '0;
    end else begin
      mem_req   <= 1'b0;
      rsp_valid <= 1'b0;
      fill      <= 1'b0;
      case (st)
        S_IDLE: if (accept) begin
          if (!in_ap) begin
            rsp_valid <= 1'b1;
            rsp_addr  <= xl_addr;
            rsp_err   <= 1'b0;
          end else if (cache_en && tlb_hit) begin
            rsp_valid <= 1'b1;
            rsp_addr  <= {tlb_ppn, xl_addr[PG_SH-1:0]};
            rsp_err   <= 1'b0;
          end else begin
            cur      <= xl_addr;
            mem_req  <= 1'b1;
            mem_addr <= {tbase, {PG_SH{1'b0}}} + {20'd0, dir_idx, 2'b00};
            st       <= S_DIR;
          end
        end
        S_DIR: if (mem_rvalid) begin
          if (!mem_rdata[0]) begin
            rsp_valid <= 1'b1;
            rsp_addr  <= '0;
            rsp_err   <= 1'b1;
            st        <= S_IDLE;
          end else begin
            mem_req  <= 1'b1;
            mem_addr <= {mem_rdata[31:PG_SH], {PG_SH{1'b0}}} + {20'd0, cur[DIR_SH-1:PG_SH], 2'b00};
            st       <= S_PT;
          end
        end
        S_PT: if (mem_rvalid) begin
          rsp_valid <= 1'b1;
          rsp_err   <= !mem_rdata[0];
          rsp_addr  <= mem_rdata[0] ? {mem_rdata[31:PG_SH], cur[PG_SH-1:0]} : '0;
          fill      <= cache_en && mem_rdata[0];
          fill_ppn  <= mem_rdata[31:PG_SH];
          st        <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_err_zero_R4: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_err) |-> (rsp_addr == 32'd0));

  assert_req_in_walk_R8: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> (st != S_IDLE));
endmodule

// File: rtl/aperture_xlate.sv
module aperture_xlate
  import apx_pkg::*;
#(
  parameter int TLB_ENTRIES  = 8,
  parameter int FLUSH_CYCLES = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [7:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        xl_valid,
  output logic        xl_ready,
  input  logic [31:0] xl_addr,
  output logic        rsp_valid,
  output logic [31:0] rsp_addr,
  output logic        rsp_err,
  output logic        mem_req,
  output logic [31:0] mem_addr,
  input  logic        mem_rvalid,
  input  logic [31:0] mem_rdata
);
  logic [7:0]       ctrl;
  logic [VPN_W-1:0] tbase;
  logic [IDX_W-1:0] abase;
  logic [MSK_W-1:0] amask;
  logic             flush_busy, flush_done, walk_idle;
  logic             tlb_hit, fill;
  logic [VPN_W-1:0] tlb_ppn, fill_vpn, fill_ppn;

  apx_regs #(.FLUSH_CYCLES(FLUSH_CYCLES)) u_regs (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .walk_idle(walk_idle),
    .ctrl(ctrl), .tbase(tbase), .abase(abase), .amask(amask),
    .flush_busy(flush_busy), .flush_done(flush_done));

  apx_tlb #(.ENTRIES(TLB_ENTRIES)) u_tlb (
    .clk(clk), .rst(rst), .lk_vpn(xl_addr[31:PG_SH]), .hit(tlb_hit), .hit_ppn(tlb_ppn),
    .fill(fill), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn), .inval(flush_done));

  apx_walker u_walk (
    .clk(clk), .rst(rst), .xl_valid(xl_valid), .xl_ready(xl_ready), .xl_addr(xl_addr),
    .rsp_valid(rsp_valid), .rsp_addr(rsp_addr), .rsp_err(rsp_err),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .cache_en(ctrl[0]), .tbase(tbase), .abase(abase), .amask(amask),
    .flush_busy(flush_busy), .tlb_hit(tlb_hit), .tlb_ppn(tlb_ppn),
    .fill(fill), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn), .walk_idle(walk_idle));

  assert_hold_off_R8: assert property (@(posedge clk) disable iff (rst)
    flush_busy |-> !xl_ready);
endmodule

// File: tb/test_aperture_xlate.sv
`timescale 1ns/1ps
module test_aperture_xlate;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_wr = 0, reg_rd = 0;
  logic [7:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic xl_valid = 0, xl_ready;
  logic [31:0] xl_addr = 0;
  logic rsp_valid, rsp_err;
  logic [31:0] rsp_addr;
  logic mem_req;
  logic [31:0] mem_addr;
  logic mem_rvalid = 0;
  logic [31:0] mem_rdata = 0;

  always #2 clk = ~clk;

  aperture_xlate i_aperture_xlate (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .xl_valid(xl_valid), .xl_ready(xl_ready),
    .xl_addr(xl_addr), .rsp_valid(rsp_valid), .rsp_addr(rsp_addr), .rsp_err(rsp_err),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata));

  int n_chk = 0, n_fail = 0;
  logic [31:0] bmem [logic [31:0]];
  logic [31:0] mlog [int];
  int reads = 0;
  int m_cnt = 0;
  logic [31:0] m_addr = 0;
  logic [32:0] exp_q [$];
  string tag_q [$];

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // memory model: two negedges of latency
  always @(negedge clk) begin
    mem_rvalid = 1'b0;
    if (m_cnt == 1) begin
      mem_rvalid = 1'b1;
      mem_rdata = bmem.exists(m_addr) ? bmem[m_addr] : 32'd0;
      m_cnt = 0;
    end else if (m_cnt > 1) m_cnt--;
    if (!rst && mem_req) begin
      m_addr = mem_addr;
      m_cnt = 2;
      mlog[reads] = mem_addr;
      reads++;
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && rsp_valid) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL unexpected response actual=%h expected=none", rsp_addr);
      end else begin
        logic [32:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk({t, " addr"}, rsp_addr, e[31:0]);
        chk({t, " err"}, {31'd0, rsp_err}, {31'd0, e[32]});
      end
    end
  end

  task automatic reg_write(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic reg_read(logic [7:0] a, output logic [31:0] d);
    reg_rd = 1; reg_addr = a;
    @(posedge clk);
    @(negedge clk);
    reg_rd = 0;
    d = reg_rdata;
  endtask

  task automatic xlate(logic [31:0] a, logic [31:0] ea, logic ee, int er, string tag);
    int r0, n;
    r0 = reads;
    exp_q.push_back({ee, ea});
    tag_q.push_back(tag);
    @(negedge clk);
    xl_valid = 1; xl_addr = a;
    while (!xl_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    xl_valid = 0;
    if (er > 0) chk("R8 ready low during walk", {31'd0, xl_ready}, 32'd0);
    n = 0;
    while (exp_q.size() != 0 && n < 80) begin @(negedge clk); n++; end
    @(negedge clk);
    chk({tag, " reads"}, reads - r0, er);
  endtask

  task automatic do_flush(logic [7:0] a, string tag);
    logic [31:0] d;
    reg_write(a, 32'd1);
    chk({tag, " ready low in flush R8"}, {31'd0, xl_ready}, 32'd0);
    reg_read(a, d);
    chk({tag, " busy"}, d, 32'd1);
    repeat (6) @(negedge clk);
    reg_read(a, d);
    chk({tag, " cleared"}, d, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] d;
    // tables: directory at 0x00100000, page tables at 0x00200000 + k*4K
    for (int k = 0; k < 9; k++)
      if (k != 5) bmem[32'h0010_0000 + 4*k] = (32'h0020_0000 + k*32'h1000) | 32'd1;
    bmem[32'h0020_0000 + 4*3] = 32'h9876_5001;
    for (int j = 16; j < 25; j++)
      bmem[32'h0020_0000 + 4*j] = 32'hA000_0000 + (j << 12) + 1;
    bmem[32'h0020_8000] = 32'h1234_0001;

    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1 ready", {31'd0, xl_ready}, 32'd1);
    chk("R1 rsp_valid", {31'd0, rsp_valid}, 32'd0);
    reg_read(8'h00, d); chk("R1 ctrl", d, 32'h0001_0000);
    reg_read(8'h0C, d); chk("R1 dir flush", d, 32'd0);
    reg_read(8'h14, d); chk("R1 post flush", d, 32'd0);
    reg_read(8'h1C, d); chk("R1 mask", d, 32'hFE00_0000);

    reg_write(8'h04, 32'h0010_0000);
    reg_write(8'h18, 32'h4000_0000);
    reg_read(8'h04, d); chk("R3 table base", d, 32'h0010_0000);
    reg_read(8'h18, d); chk("R2 aperture base", d, 32'h4000_0000);
    // R9 illegal mask ignored, low bits read zero
    reg_write(8'h1C, 32'h1234_5678);
    reg_read(8'h1C, d); chk("R9 illegal mask ignored", d, 32'hFE00_0000);
    reg_write(8'h1C, 32'hFE00_1234);
    reg_read(8'h1C, d); chk("R9 low bits zero", d, 32'hFE00_0000);

    // R2 pass-through
    xlate(32'h1234_5678, 32'h1234_5678, 0, 0, "R2 below");
    xlate(32'h4200_0000, 32'h4200_0000, 0, 0, "R2 above");

    // R3 walk
    xlate(32'h4000_3ABC, 32'h9876_5ABC, 0, 2, "R3 walk");
    chk("R3 dir addr", mlog[reads-2], 32'h0010_0000);
    chk("R3 pte addr", mlog[reads-1], 32'h0020_000C);
    // R5 hit
    xlate(32'h4000_3FFF, 32'h9876_5FFF, 0, 0, "R5 hit");

    // R4 invalid entries
    xlate(32'h4140_0000, 32'h0, 1, 1, "R4 dir invalid");
    xlate(32'h4000_4000, 32'h0, 1, 2, "R4 pte invalid");

    // R7 posted flush then directory flush
    do_flush(8'h14, "R7 posted");
    xlate(32'h4000_3ABC, 32'h9876_5ABC, 0, 2, "R7 walk after posted flush");
    do_flush(8'h0C, "R7 directory");
    xlate(32'h4000_3ABC, 32'h9876_5ABC, 0, 2, "R7 walk after dir flush");

    // R6 cache disabled
    reg_write(8'h00, 32'h0);
    reg_read(8'h00, d); chk("R6 ctrl off", d, 32'h0);
    xlate(32'h4000_3ABC, 32'h9876_5ABC, 0, 2, "R6 walk 1");
    xlate(32'h4000_3ABC, 32'h9876_5ABC, 0, 2, "R6 walk 2");
    reg_write(8'h00, 32'h0001_0000);

    // R10 round robin
    do_flush(8'h14, "R10 flush");
    for (int j = 16; j < 25; j++)
      xlate(32'h4000_0000 + (j << 12), 32'hA000_0000 + (j << 12), 0, 2, "R10 fill");
    xlate(32'h4001_1010, 32'hA001_1010, 0, 0, "R10 second page hits");
    xlate(32'h4001_0020, 32'hA001_0020, 0, 2, "R10 first page evicted");

    // R9 larger aperture
    reg_write(8'h1C, 32'hF000_0000);
    reg_read(8'h1C, d); chk("R9 legal mask", d, 32'hF000_0000);
    xlate(32'h4200_0044, 32'h1234_0044, 0, 2, "R9 inside larger aperture");

    repeat (4) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule